// File: doc/BRIEF.md
# I/O MMU Context Control and Fault Register Bank

This block is the software-visible register bank of a small I/O memory management unit. It holds a set of translation contexts and an array of per-master micro-TLB control entries, all reached through a plain 32-bit register bus. The read data is combinational and the writes take effect on the clock edge.

Each context keeps a control word, a translation table base that is split into a low word and an upper byte (a 40-bit output address), a fault status word and the address of the fault. A translation engine, stubbed here, reports faults through a one-cycle fault strobe. The bank latches the first fault of a context and raises an interrupt while an enabled context holds a fault. Software starts a TLB invalidation by setting the flush bit and polls that bit until it drops. Each micro-TLB entry binds one bus master to a context or to the fixed-mapping table, and can send a flush pulse to that master's micro-TLB.

Top module: `iommu_ctx_bank`

## Requirements
- R1: After reset every context control word, base register, status word and fault address reads 0. `irq_o`, `ctx_en_o`, `utlb_en_o`, `utlb_sel_o` and `utlb_flush_o` are all 0.
- R2: Context c occupies byte addresses c*0x40 to c*0x40+0x3F. Its registers sit at these offsets: control at 0x00, table base low word at 0x10, table base upper byte at 0x14 (bits 7:0 kept, the rest read 0), status at 0x20 and fault address at 0x30. Any other offset, and any address outside the context and micro-TLB ranges, reads 0 and ignores writes.
- R3: Only these control bits are stored: 0 (enable), 2 (interrupt enable), 3, 5:4, 16 and 17. All other control bits read 0. `ctx_en_o[c]` follows bit 0 of context c.
- R4: Writing 1 to control bit 1 starts an invalidation. Bit 1 reads 1 for FLUSH_CYCLES clock edges after the write edge and then reads 0. A control write with bit 1 at 0 does not cancel a running invalidation. A second write of 1 restarts the count.
- R5: A fault strobe with nonzero flags, aimed at a context whose status is empty, latches into that context. The status word is built as follows: flag input bit 0 goes to bit 0 (translation fault), bit 1 to bit 1 (page fault), bit 2 to bit 2 (walk abort) and bit 3 to bit 4 (multiple hit). The error code goes to bits 10:8 and the level to bits 13:12. The faulting address is latched as well.
- R6: A fault aimed at a context whose status still holds a flag is dropped, so the first flags, code, level and address are kept. A fault strobe with all flags at 0 is ignored.
- R7: Writing 0 to the status register clears the context's status. A nonzero write to the status register has no effect. A clear and a fault in the same cycle leave the status empty.
- R8: The fault address register reads the latched address while any status flag is set, and reads 0 once the status is cleared.
- R9: `irq_o` is high exactly when at least one context has its interrupt-enable bit set and a nonzero status flag.
- R10: Micro-TLB entry n occupies 0x300+16*n, for NUTLB entries. Its control word at +0 stores bit 0 (enable, driving `utlb_en_o[n]`) and bits 7:4 (table select, driving `utlb_sel_o[4n+3:4n]`; 0 to 3 name a context and 8 names the fixed-mapping table). Writing 1 to bit 1 makes `utlb_flush_o[n]` high for exactly the cycle after the write; bit 1 reads 0. The ID word at +8 keeps bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address; 0 when not reading |
| fault_valid_i | input | 1 | Fault report strobe from the translation engine |
| fault_ctx_i | input | CTX_W | Context of the reported fault |
| fault_flags_i | input | 4 | {multiple hit, walk abort, page fault, translation fault} |
| fault_code_i | input | 3 | Error code |
| fault_level_i | input | 2 | Table level of the fault |
| fault_addr_i | input | 32 | Faulting input address |
| irq_o | output | 1 | Fault interrupt |
| ctx_en_o | output | NCTX | Per-context translation enable |
| utlb_en_o | output | NUTLB | Per-master micro-TLB enable |
| utlb_sel_o | output | 4*NUTLB | Per-master table select |
| utlb_flush_o | output | NUTLB | One-cycle micro-TLB flush pulse |

## Verification
The bench builds the bank with four contexts and 32 micro-TLB entries, which are the default sizes. It shortens FLUSH_CYCLES to 5, so that every cycle of an invalidation can be polled, and so can a restart or an attempted cancel in the middle of one. With 32 entries the highest micro-TLB entry (0x4F0) is in range, as are the first unmapped words past it and the gap between the contexts and the entries. Faults reach contexts with interrupts both enabled and disabled, which covers the dropped second fault, the nonzero status write and the clear that meets a fault in the same cycle.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;
  localparam int DATA_W = 32;

  localparam logic [5:0] OFF_CTRL    = 6'h00;
  localparam logic [5:0] OFF_BASE_LO = 6'h10;
  localparam logic [5:0] OFF_BASE_HI = 6'h14;
  localparam logic [5:0] OFF_STATUS  = 6'h20;
  localparam logic [5:0] OFF_FADDR   = 6'h30;

  localparam logic [3:0] UOFF_CTRL = 4'h0;
  localparam logic [3:0] UOFF_ID   = 4'h8;

  // stored control bits: 0,2,3,5:4,16,17 (bit 1 is the flush strobe)
  localparam logic [31:0] CTRL_WMASK = 32'h0003_003D;
  localparam int FLUSH_BIT = 1;

  typedef struct packed {
    logic [3:0]  flags;
    logic [2:0]  code;
    logic [1:0]  level;
    logic [31:0] addr;
  } fault_rec_t;

  function automatic logic [31:0] status_word(fault_rec_t r);
    return {18'b0, r.level, 1'b0, r.code, 3'b0, r.flags[3], 1'b0, r.flags[2:0]};
  endfunction
endpackage

// File: rtl/iommu_ctx_regs.sv
module iommu_ctx_regs
  import iommu_regs_pkg::*;
#(
  parameter int FLUSH_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [5:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic        fault_en_i,
  input  fault_rec_t  fault_i,
  output logic [31:0] rdata_o,
  output logic        en_o,
  output logic        irq_o
);
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FLUSH_CYCLES);

  logic [31:0]      ctrl_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      base_lo_q;
  logic [7:0]       base_hi_q;
  fault_rec_t       rec_q;

  logic wr_ctrl, flush_start, clr, pending, take_fault;

  assign wr_ctrl     = wr_en_i && (off_i == OFF_CTRL);
  assign flush_start = wr_ctrl && wdata_i[FLUSH_BIT];
  assign clr         = wr_en_i && (off_i == OFF_STATUS) && (wdata_i == '0);
  assign pending     = |rec_q.flags;
  assign take_fault  = fault_en_i && (|fault_i.flags) && !pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      rec_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i & CTRL_WMASK;
      if (flush_start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
      if (wr_en_i && off_i == OFF_BASE_LO) base_lo_q <= wdata_i;
      if (wr_en_i && off_i == OFF_BASE_HI) base_hi_q <= wdata_i[7:0];
      // clear has priority; a fault meeting the clear is dropped
      if (clr)             rec_q <= '0;
      else if (take_fault) rec_q <= fault_i;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CTRL:    rdata_o = ctrl_q | (32'(busy_q) << FLUSH_BIT);
      OFF_BASE_LO: rdata_o = base_lo_q;
      OFF_BASE_HI: rdata_o = {24'b0, base_hi_q};
      OFF_STATUS:  rdata_o = status_word(rec_q);
      OFF_FADDR:   rdata_o = pending ? rec_q.addr : 32'b0;
      default:     rdata_o = 32'b0;
    endcase
  end

  assign en_o  = ctrl_q[0];
  assign irq_o = ctrl_q[2] && pending;

  a_r4_flush_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_start |=> busy_q);
  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_LOAD));
  a_r6_first_fault_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && !clr) |=> ($stable(rec_q.addr) && $stable(rec_q.flags)));
  a_r7_zero_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !pending);
endmodule

// File: rtl/iommu_utlb_entry.sv
module iommu_utlb_entry
  import iommu_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] id_o,
  output logic        en_o,
  output logic [3:0]  sel_o,
  output logic        flush_o
);
  logic       en_q, flush_q;
  logic [3:0] sel_q;
  logic [15:0] id_q;
  logic wr_ctrl;

  assign wr_ctrl = wr_en_i && (off_i == UOFF_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      id_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_ctrl && wdata_i[FLUSH_BIT];
      if (wr_ctrl) begin
        en_q  <= wdata_i[0];
        sel_q <= wdata_i[7:4];
      end
      if (wr_en_i && off_i == UOFF_ID) id_q <= wdata_i[15:0];
    end
  end

  assign ctrl_o  = {24'b0, sel_q, 3'b0, en_q};
  assign id_o    = {16'b0, id_q};
  assign en_o    = en_q;
  assign sel_o   = sel_q;
  assign flush_o = flush_q;

  a_r10_flush_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_en_i && off_i == UOFF_CTRL && wdata_i[FLUSH_BIT]));
endmodule

// File: rtl/iommu_ctx_bank.sv
module iommu_ctx_bank
  import iommu_regs_pkg::*;
#(
  parameter int NCTX         = 4,
  parameter int NUTLB        = 32,
  parameter int FLUSH_CYCLES = 16,
  parameter int ADDR_W       = 12,
  localparam int CTX_W       = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               fault_valid_i,
  input  logic [CTX_W-1:0]   fault_ctx_i,
  input  logic [3:0]         fault_flags_i,
  input  logic [2:0]         fault_code_i,
  input  logic [1:0]         fault_level_i,
  input  logic [31:0]        fault_addr_i,
  output logic               irq_o,
  output logic [NCTX-1:0]    ctx_en_o,
  output logic [NUTLB-1:0]   utlb_en_o,
  output logic [NUTLB*4-1:0] utlb_sel_o,
  output logic [NUTLB-1:0]   utlb_flush_o
);
  localparam int UTLB_W = (NUTLB > 1) ? $clog2(NUTLB) : 1;
  localparam logic [ADDR_W-1:0] CTX_END   = ADDR_W'(NCTX * 64);
  localparam logic [ADDR_W-1:0] UTLB_BASE = ADDR_W'(12'h300);
  localparam logic [ADDR_W-1:0] UTLB_END  = ADDR_W'(12'h300 + NUTLB * 16);

  logic              wr, rd;
  logic              ctx_hit, utlb_hit;
  logic [CTX_W-1:0]  ctx_idx;
  logic [ADDR_W-1:0] utlb_rel;
  logic [UTLB_W-1:0] utlb_idx;
  fault_rec_t        fault_rec;

  logic [31:0]     ctx_rdata [NCTX];
  logic [NCTX-1:0] ctx_irq;
  logic [31:0]     u_ctrl [NUTLB];
  logic [31:0]     u_id   [NUTLB];

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign ctx_hit  = addr_i < CTX_END;
  assign ctx_idx  = addr_i[6 +: CTX_W];
  assign utlb_hit = (addr_i >= UTLB_BASE) && (addr_i < UTLB_END);
  assign utlb_rel = addr_i - UTLB_BASE;
  assign utlb_idx = utlb_rel[4 +: UTLB_W];

  assign fault_rec = '{flags: fault_flags_i, code: fault_code_i,
                       level: fault_level_i, addr: fault_addr_i};

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    iommu_ctx_regs #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr && ctx_hit && (ctx_idx == CTX_W'(c))),
      .off_i      (addr_i[5:0]),
      .wdata_i    (wdata_i),
      .fault_en_i (fault_valid_i && (fault_ctx_i == CTX_W'(c))),
      .fault_i    (fault_rec),
      .rdata_o    (ctx_rdata[c]),
      .en_o       (ctx_en_o[c]),
      .irq_o      (ctx_irq[c])
    );
  end

  for (genvar u = 0; u < NUTLB; u++) begin : g_utlb
    iommu_utlb_entry u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr && utlb_hit && (utlb_idx == UTLB_W'(u))),
      .off_i   (addr_i[3:0]),
      .wdata_i (wdata_i),
      .ctrl_o  (u_ctrl[u]),
      .id_o    (u_id[u]),
      .en_o    (utlb_en_o[u]),
      .sel_o   (utlb_sel_o[u*4 +: 4]),
      .flush_o (utlb_flush_o[u])
    );
  end

  always_comb begin
    rdata_o = 32'b0;
    if (rd && ctx_hit) begin
      rdata_o = ctx_rdata[ctx_idx];
    end else if (rd && utlb_hit) begin
      if (addr_i[3:0] == UOFF_CTRL)    rdata_o = u_ctrl[utlb_idx];
      else if (addr_i[3:0] == UOFF_ID) rdata_o = u_id[utlb_idx];
    end
  end

  assign irq_o = |ctx_irq;

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (ctx_en_o == '0) && (utlb_en_o == '0));
endmodule

// File: tb/sim_iommu_ctx_bank.sv
module sim_iommu_ctx_bank;
  localparam int NC = 4, NU = 32, FL = 5;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic fv = 0;
  logic [1:0] fctx = 0;
  logic [3:0] fflags = 0;
  logic [2:0] fcode = 0;
  logic [1:0] flvl = 0;
  logic [31:0] faddr = 0;
  logic irq;
  logic [NC-1:0] ctx_en;
  logic [NU-1:0] uen, ufl;
  logic [NU*4-1:0] usel;

  always #4 clk = ~clk;

  iommu_ctx_bank #(.NCTX(NC), .NUTLB(NU), .FLUSH_CYCLES(FL), .ADDR_W(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fault_valid_i(fv), .fault_ctx_i(fctx),
    .fault_flags_i(fflags), .fault_code_i(fcode), .fault_level_i(flvl),
    .fault_addr_i(faddr), .irq_o(irq), .ctx_en_o(ctx_en), .utlb_en_o(uen),
    .utlb_sel_o(usel), .utlb_flush_o(ufl));

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model
  int m_ctrl[NC], m_cnt[NC], m_lo[NC], m_hi[NC], m_st[NC], m_fa[NC];
  bit m_busy[NC];
  int m_uen[NU], m_usel[NU], m_uid[NU], m_ufl[NU];

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      m_ctrl[c] = 0; m_cnt[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_st[c] = 0; m_fa[c] = 0; m_busy[c] = 0;
    end
    for (int u = 0; u < NU; u++) begin
      m_uen[u] = 0; m_usel[u] = 0; m_uid[u] = 0; m_ufl[u] = 0;
    end
  endtask

  task automatic model_step();
    int a, c, o, u;
    bit w, clr;
    w = req && we; a = int'(addr);
    for (int k = 0; k < NU; k++) m_ufl[k] = 0;
    for (int k = 0; k < NC; k++) begin
      clr = w && a == k*64 + 32 && wdata == 0;
      if (w && a == k*64 && wdata[1]) begin m_busy[k] = 1; m_cnt[k] = FL; end
      else if (m_busy[k]) begin m_cnt[k]--; if (m_cnt[k] == 0) m_busy[k] = 0; end
      if (clr) begin m_st[k] = 0; m_fa[k] = 0; end
      else if (fv && int'(fctx) == k && fflags != 0 && (m_st[k] & 'h17) == 0) begin
        m_st[k] = (int'(flvl) << 12) | (int'(fcode) << 8) | (int'(fflags[3]) << 4) | int'(fflags[2:0]);
        m_fa[k] = int'(faddr);
      end
    end
    if (w && a < NC*64) begin
      c = a / 64; o = a % 64;
      if (o == 0) m_ctrl[c] = int'(wdata) & 'h3003D;
      if (o == 'h10) m_lo[c] = int'(wdata);
      if (o == 'h14) m_hi[c] = int'(wdata) & 'hFF;
    end
    if (w && a >= 'h300 && a < 'h300 + NU*16) begin
      u = (a - 'h300) / 16; o = a % 16;
      if (o == 0) begin m_uen[u] = int'(wdata[0]); m_usel[u] = int'(wdata[7:4]); m_ufl[u] = int'(wdata[1]); end
      if (o == 8) m_uid[u] = int'(wdata) & 'hFFFF;
    end
  endtask

  function automatic int model_read(int a);
    int c, o, u;
    if (a < NC*64) begin
      c = a / 64; o = a % 64;
      case (o)
        0:    return m_ctrl[c] | (int'(m_busy[c]) << 1);
        'h10: return m_lo[c];
        'h14: return m_hi[c];
        'h20: return m_st[c];
        'h30: return (m_st[c] & 'h17) != 0 ? m_fa[c] : 0;
        default: return 0;
      endcase
    end
    if (a >= 'h300 && a < 'h300 + NU*16) begin
      u = (a - 'h300) / 16; o = a % 16;
      if (o == 0) return (m_usel[u] << 4) | m_uen[u];
      if (o == 8) return m_uid[u];
    end
    return 0;
  endfunction

  // per-clock comparison of all outputs
  always @(posedge clk) begin
    logic [NC-1:0] e_en; logic [NU-1:0] e_uen, e_ufl; logic [NU*4-1:0] e_sel; bit e_irq;
    if (rst_n) model_step();
    #2;
    e_irq = 0;
    for (int c = 0; c < NC; c++) begin
      e_en[c] = m_ctrl[c][0];
      if (m_ctrl[c][2] && (m_st[c] & 'h17) != 0) e_irq = 1;
    end
    for (int u = 0; u < NU; u++) begin
      e_uen[u] = m_uen[u][0]; e_ufl[u] = m_ufl[u][0]; e_sel[u*4 +: 4] = 4'(m_usel[u]);
    end
    check(irq === e_irq, "R9 irq_o", 128'(irq), 128'(e_irq));
    check(ctx_en === e_en, "R3 ctx_en_o", 128'(ctx_en), 128'(e_en));
    check(uen === e_uen && usel === e_sel, "R10 utlb en/sel", {uen, usel[95:0]}, {e_uen, e_sel[95:0]});
    check(ufl === e_ufl, "R10 utlb_flush_o", 128'(ufl), 128'(e_ufl));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); req = 1; we = 1; addr = 12'(a); wdata = 32'(d);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input int a, input string tag);
    int e;
    @(negedge clk); req = 1; we = 0; addr = 12'(a);
    #1; e = model_read(a);
    check(rdata === 32'(e), tag, 128'(rdata), 128'(e));
    req = 0;
  endtask

  task automatic flt(input int c, input int fl, input int cd, input int lv, input int fa);
    @(negedge clk); fv = 1; fctx = 2'(c); fflags = 4'(fl); fcode = 3'(cd); flvl = 2'(lv); faddr = 32'(fa);
    @(negedge clk); fv = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rd(c*64, "R1 ctrl"); rd(c*64 + 'h20, "R1 status"); rd(c*64 + 'h30, "R1 faddr"); rd(c*64 + 'h10, "R1 base");
    end
    rd('h300, "R1 utlb ctrl");
    // R3 control mask
    wr(64, 'hFFFF_FFFD); rd(64, "R3 ctrl mask");
    wr(64*3, 'h0000_0031); rd(64*3, "R3 ctrl sel");
    // R2 map and base split
    wr(128 + 'h10, 'hDEAD_BEEF); wr(128 + 'h14, 'h0000_1234);
    rd(128 + 'h10, "R2 base lo"); rd(128 + 'h14, "R2 base hi");
    rd(64 + 'h10, "R2 other ctx untouched");
    wr(128 + 'h3C, 'h5555_5555); rd(128 + 'h3C, "R2 unmapped offset");
    wr('h200, 'h1234); rd('h200, "R2 gap read");
    wr('h500, 'h1); rd('h500, "R2 past utlb");
    // R4 flush lifetime
    wr(0, 'h2);
    for (int i = 0; i < FL + 2; i++) rd(0, "R4 flush poll");
    wr(0, 'h2); wr(0, 'h1);
    for (int i = 0; i < FL + 2; i++) rd(0, "R4 no cancel");
    wr(0, 'h2); rd(0, "R4 restart a"); wr(0, 'h2);
    for (int i = 0; i < FL + 2; i++) rd(0, "R4 restart poll");
    // R5/R6/R7/R8 faults
    wr(64, 'h5);
    flt(1, 'hA, 4, 2, 'h1000_0040);
    rd(64 + 'h20, "R5 status"); rd(64 + 'h30, "R5 fault addr");
    flt(1, 'h1, 1, 1, 'h2222_0000);
    rd(64 + 'h20, "R6 status kept"); rd(64 + 'h30, "R6 addr kept");
    flt(2, 'h0, 5, 3, 'h3333_0000); rd(128 + 'h20, "R6 zero flags ignored");
    wr(64 + 'h20, 'h17); rd(64 + 'h20, "R7 nonzero write ignored");
    wr(64 + 'h20, 0); rd(64 + 'h20, "R7 cleared"); rd(64 + 'h30, "R8 addr zero");
    flt(3, 'h4, 5, 1, 'h4444_4444); rd(192 + 'h20, "R5 ctx3 status"); rd(192 + 'h30, "R8 addr held");
    flt(0, 'h2, 1, 3, 'h0BAD_0000);
    wr(0, 'h4); rd(0 + 'h20, "R9 ctx0 enabled");
    wr(0 + 'h20, 0); wr(192 + 'h20, 0);
    // R7 clear meets fault
    flt(1, 'h1, 4, 2, 'h5000_0000);
    @(negedge clk); req = 1; we = 1; addr = 12'(64 + 'h20); wdata = 0;
    fv = 1; fctx = 1; fflags = 4'h2; fcode = 3'd5; faddr = 32'h6000_0000;
    @(negedge clk); req = 0; we = 0; fv = 0;
    rd(64 + 'h20, "R7 clear beats fault"); rd(64 + 'h30, "R8 after clash");
    // R10 micro-TLB entries
    wr('h300, 'h33); wr('h300 + 17*16, 'h81); wr('h300 + 31*16, 'h23);
    wr('h300 + 31*16 + 8, 'hABCD_1234);
    rd('h300, "R10 entry0"); rd('h300 + 17*16, "R10 entry17"); rd('h300 + 31*16, "R10 entry31");
    rd('h300 + 31*16 + 8, "R10 id"); rd('h300 + 31*16 + 4, "R10 hole");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule